// File: doc/BRIEF.md
# Selectable-Ratio Clock Fanout Controller

This block takes one input clock and produces six differential host clock pairs and one complementary reference pair. Each pair runs at the input rate, half of it or a quarter of it, or is switched off, depending on a 3-bit select code. The two outer host pairs (index 0 and index 5) decode the code differently from the four inner pairs. All divided phases come from one shared 2-bit counter, so every output with the same ratio switches on the same input edge. A new select code is taken in only when that counter wraps to zero, so a ratio change never produces a short pulse.

Two inputs override the select code. A test-disable input switches every pair off. An asynchronous active-low power-down input wins over everything: it forces a safe state in which each host true leg is driven high, each host complement leg is released, and both reference legs are held low. Each leg has its own enable flag, which stands in for a high-impedance driver. Release from power-down goes through a two-stage synchroniser, and the counter starts again from zero before any output runs. A separate 2-bit current code is decoded into a numeric multiplier for reporting.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: With power-down high and test-disable low, the select code {sel_i[2],sel_i[1],sel_i[0]} sets the inner host pairs 1..4 to: 000 /2, 001 /2, 010 /2, 011 /4, 100 /1, 101 /1, 110 /1, 111 /2.
- R2: Under the same conditions, the outer host pairs 0 and 5 follow: 000 /2, 001 off, 010 /4, 011 /4, 100 /1, 101 off, 110 /2, 111 /2. An off pair has both leg enables low and both data legs low.
- R3: The reference pair runs at /4 for every select code except 111, where it runs at /2.
- R4: With power-down high and test-disable high, every leg enable of every pair is low and every data leg is low, whatever the select code.
- R5: Power-down low forces, without waiting for a clock edge and regardless of test-disable: every host_t_o leg high with its enable high, every host complement enable low, and ref_t_o, ref_c_o low with both reference enables high.
- R6: After power-down returns high, the safe state of R5 holds through the first rising input edge; from the second rising edge the outputs run, with the counter at zero (a /2 output is low during that cycle and high during the next).
- R7: A select code applied while the counter is not at its last state takes effect only from the cycle after the next wrap of the counter to zero.
- R8: mult_o reports the current multiplier for mult_code_i: 00 gives 5, 01 gives 6, 10 gives 4, 11 gives 7.
- R9: The input values that undriven pins settle to (select 000, test-disable low, mult_code_i 01, power-down high) give hosts at /2, reference at /4 and a multiplier of 6.
- R10: On a running pair the complement leg is the inverse of the true leg; divided outputs have a 50% duty cycle, and all outputs at the same ratio are in phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock that is divided and fanned out |
| pd_n_i | input | 1 | Asynchronous power-down, active low |
| tst_dis_i | input | 1 | Test disable: turns every pair off while high |
| sel_i | input | 3 | Ratio select code; bit 2 is the most significant |
| mult_code_i | input | 2 | Output current multiplier code |
| host_t_o | output | 6 | Host true legs |
| host_c_o | output | 6 | Host complement legs |
| host_t_en_o | output | 6 | Drive enables of the host true legs |
| host_c_en_o | output | 6 | Drive enables of the host complement legs |
| ref_t_o | output | 1 | Reference true leg |
| ref_c_o | output | 1 | Reference complement leg |
| ref_t_en_o | output | 1 | Drive enable of the reference true leg |
| ref_c_en_o | output | 1 | Drive enable of the reference complement leg |
| mult_o | output | 3 | Decoded current multiplier value |

## Verification
A counter that skips or sticks shows within one 4-cycle period as a wrong count of rising edges on the /2 and /4 outputs, and as a reference leg out of step with the hosts. A select register loaded at the wrong time shows as a ratio change one to three cycles early, which the bench exposes by locating the wrap from the reference output and probing the cycle before it. A wrong synchroniser depth or a counter that is not cleared on release shows in the first two cycles after power-down lifts, as an output that starts one edge early or in the wrong phase.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

  localparam int SEL_W   = 3;
  localparam int MULT_W  = 2;
  localparam int MULTV_W = 3;
  localparam int DIV_W   = 2;

  typedef enum logic [1:0] {
    RT_OFF = 2'd0,
    RT_D1  = 2'd1,
    RT_D2  = 2'd2,
    RT_D4  = 2'd3
  } ratio_e;

  // Inner host pairs
  function automatic ratio_e inner_ratio(input logic [SEL_W-1:0] s);
    case (s)
      3'b011:                 return RT_D4;
      3'b100, 3'b101, 3'b110: return RT_D1;
      default:                return RT_D2;
    endcase
  endfunction

  // Outer host pairs
  function automatic ratio_e outer_ratio(input logic [SEL_W-1:0] s);
    case (s)
      3'b001, 3'b101: return RT_OFF;
      3'b010, 3'b011: return RT_D4;
      3'b100:         return RT_D1;
      default:        return RT_D2;
    endcase
  endfunction

  // Reference pair
  function automatic ratio_e ref_ratio(input logic [SEL_W-1:0] s);
    return (s == 3'b111) ? RT_D2 : RT_D4;
  endfunction

  function automatic logic [MULTV_W-1:0] mult_value(input logic [MULT_W-1:0] c);
    case (c)
      2'b00:   return 3'd5;
      2'b01:   return 3'd6;
      2'b10:   return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/fanout_divider.sv
module fanout_divider
  import fanout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             pd_n_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             run_o,
  output logic             ph2_o,
  output logic             ph4_o,
  output logic [SEL_W-1:0] sel_q_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DIV_W-1:0]       cnt_q;
  logic [SEL_W-1:0]       sel_q;
  logic                   run;
  logic                   wrap;

  // Release synchroniser: asserts asynchronously, releases on clock edges
  always_ff @(posedge clk_i or negedge pd_n_i) begin
    if (!pd_n_i) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign run  = sync_q[SYNC_STAGES-1];
  assign wrap = (cnt_q == {DIV_W{1'b1}});

  // Shared divider counter, held at zero until the outputs run
  always_ff @(posedge clk_i or negedge pd_n_i) begin
    if (!pd_n_i)  cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // Select code is taken only at the wrap (or while stopped)
  always_ff @(posedge clk_i or negedge pd_n_i) begin
    if (!pd_n_i)           sel_q <= '0;
    else if (!run || wrap) sel_q <= sel_i;
  end

  assign run_o   = run;
  assign ph2_o   = cnt_q[0];
  assign ph4_o   = cnt_q[DIV_W-1];
  assign sel_q_o = sel_q;

  // R7
  sel_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!pd_n_i)
    (sel_q != $past(sel_q)) |-> ($past(wrap) || !$past(run)));

  // R6
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!pd_n_i)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/fanout_leg.sv
module fanout_leg
  import fanout_pkg::*;
#(
  parameter bit IS_REF = 1'b0
) (
  input  logic   clk_i,
  input  logic   pd_n_i,
  input  logic   run_i,
  input  logic   tst_dis_i,
  input  ratio_e ratio_i,
  input  logic   ph2_i,
  input  logic   ph4_i,
  output logic   t_o,
  output logic   c_o,
  output logic   t_en_o,
  output logic   c_en_o
);

  logic en1_q;
  logic wave;
  logic safe_t, safe_c, safe_t_en, safe_c_en;

  // Safe state differs between the host and reference variants
  generate
    if (IS_REF) begin : g_ref_safe
      assign safe_t    = 1'b0;
      assign safe_c    = 1'b0;
      assign safe_t_en = 1'b1;
      assign safe_c_en = 1'b1;
    end else begin : g_host_safe
      assign safe_t    = 1'b1;
      assign safe_c    = 1'b0;
      assign safe_t_en = 1'b1;
      assign safe_c_en = 1'b0;
    end
  endgenerate

  // The undivided path opens and closes while the input clock is low
  always_ff @(negedge clk_i or negedge pd_n_i) begin
    if (!pd_n_i) en1_q <= 1'b0;
    else         en1_q <= run_i && (ratio_i == RT_D1);
  end

  assign wave = (clk_i & en1_q)
              | (ph2_i & (ratio_i == RT_D2))
              | (ph4_i & (ratio_i == RT_D4));

  always_comb begin
    if (!pd_n_i || !run_i) begin
      t_o = safe_t;  c_o = safe_c;  t_en_o = safe_t_en;  c_en_o = safe_c_en;
    end else if (tst_dis_i || ratio_i == RT_OFF) begin
      t_o = 1'b0;  c_o = 1'b0;  t_en_o = 1'b0;  c_en_o = 1'b0;
    end else begin
      t_o = wave;  c_o = ~wave;  t_en_o = 1'b1;  c_en_o = 1'b1;
    end
  end

  // R10
  div2_toggle_chk: assert property (@(posedge clk_i) disable iff (!pd_n_i)
    (run_i && $past(run_i) && !tst_dis_i && !$past(tst_dis_i) &&
     ratio_i == RT_D2 && $past(ratio_i) == RT_D2) |-> (t_o != $past(t_o)));

endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import fanout_pkg::*;
#(
  parameter int N_HOST      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_in,
  input  logic               pd_n_i,
  input  logic               tst_dis_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [MULT_W-1:0]  mult_code_i,
  output logic [N_HOST-1:0]  host_t_o,
  output logic [N_HOST-1:0]  host_c_o,
  output logic [N_HOST-1:0]  host_t_en_o,
  output logic [N_HOST-1:0]  host_c_en_o,
  output logic               ref_t_o,
  output logic               ref_c_o,
  output logic               ref_t_en_o,
  output logic               ref_c_en_o,
  output logic [MULTV_W-1:0] mult_o
);

  logic             run_w;
  logic             ph2_w;
  logic             ph4_w;
  logic [SEL_W-1:0] sel_q_w;
  ratio_e           ref_ratio_w;

  fanout_divider #(.SYNC_STAGES(SYNC_STAGES)) u_div (
    .clk_i   (clk_in),
    .pd_n_i  (pd_n_i),
    .sel_i   (sel_i),
    .run_o   (run_w),
    .ph2_o   (ph2_w),
    .ph4_o   (ph4_w),
    .sel_q_o (sel_q_w)
  );

  genvar g;
  generate
    for (g = 0; g < N_HOST; g++) begin : g_host
      localparam bit OUTER = (g == 0) || (g == N_HOST - 1);
      ratio_e leg_ratio;
      assign leg_ratio = OUTER ? outer_ratio(sel_q_w) : inner_ratio(sel_q_w);

      fanout_leg #(.IS_REF(1'b0)) u_leg (
        .clk_i     (clk_in),
        .pd_n_i    (pd_n_i),
        .run_i     (run_w),
        .tst_dis_i (tst_dis_i),
        .ratio_i   (leg_ratio),
        .ph2_i     (ph2_w),
        .ph4_i     (ph4_w),
        .t_o       (host_t_o[g]),
        .c_o       (host_c_o[g]),
        .t_en_o    (host_t_en_o[g]),
        .c_en_o    (host_c_en_o[g])
      );
    end
  endgenerate

  assign ref_ratio_w = ref_ratio(sel_q_w);

  fanout_leg #(.IS_REF(1'b1)) u_ref (
    .clk_i     (clk_in),
    .pd_n_i    (pd_n_i),
    .run_i     (run_w),
    .tst_dis_i (tst_dis_i),
    .ratio_i   (ref_ratio_w),
    .ph2_i     (ph2_w),
    .ph4_i     (ph4_w),
    .t_o       (ref_t_o),
    .c_o       (ref_c_o),
    .t_en_o    (ref_t_en_o),
    .c_en_o    (ref_c_en_o)
  );

  assign mult_o = mult_value(mult_code_i);

  // R5
  pd_safe_chk: assert property (@(negedge clk_in)
    !run_w |-> (host_t_o == '1 && host_c_en_o == '0 && host_t_en_o == '1 &&
                !ref_t_o && !ref_c_o));

  // R2
  outer_off_chk: assert property (@(negedge clk_in) disable iff (!pd_n_i)
    (run_w && !host_t_en_o[0]) |-> (!host_t_o[0] && !host_c_o[0] && !host_c_en_o[0]));

endmodule

// File: tb/clk_fanout_ctrl_tb_top.sv
module clk_fanout_ctrl_tb_top;

  localparam int P = 10;
  localparam int NH = 6;

  logic       clk = 1'b0;
  logic       pd_n = 1'b0;
  logic       tst = 1'b0;
  logic [2:0] sel = 3'b000;
  logic [1:0] mcode = 2'b01;
  logic [NH-1:0] ht, hc, hte, hce;
  logic rt, rc, rte, rce;
  logic [2:0] mult;

  int n_chk = 0;
  int n_bad = 0;

  always #(P/2) clk = ~clk;

  clk_fanout_ctrl dut_i (
    .clk_in(clk), .pd_n_i(pd_n), .tst_dis_i(tst), .sel_i(sel), .mult_code_i(mcode),
    .host_t_o(ht), .host_c_o(hc), .host_t_en_o(hte), .host_c_en_o(hce),
    .ref_t_o(rt), .ref_c_o(rc), .ref_t_en_o(rte), .ref_c_en_o(rce), .mult_o(mult)
  );

  // {pd_n, tst, sel[2:0], inner_div[2:0], outer_div[2:0], ref_div[2:0]}
  // divisor 0 = off, 7 = power-down safe state
  localparam logic [13:0] VEC [0:9] = '{
    {1'b1, 1'b0, 3'b000, 3'd2, 3'd2, 3'd4},
    {1'b1, 1'b0, 3'b001, 3'd2, 3'd0, 3'd4},
    {1'b1, 1'b0, 3'b010, 3'd2, 3'd4, 3'd4},
    {1'b1, 1'b0, 3'b011, 3'd4, 3'd4, 3'd4},
    {1'b1, 1'b0, 3'b100, 3'd1, 3'd1, 3'd4},
    {1'b1, 1'b0, 3'b101, 3'd1, 3'd0, 3'd4},
    {1'b1, 1'b0, 3'b110, 3'd1, 3'd2, 3'd4},
    {1'b1, 1'b0, 3'b111, 3'd2, 3'd2, 3'd2},
    {1'b1, 1'b1, 3'b101, 3'd0, 3'd0, 3'd0},
    {1'b0, 1'b1, 3'b000, 3'd7, 3'd7, 3'd7}
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_safe(input string req, input string what);
    chk(ht == '1, req, {what, " host true legs"}, ht, 6'h3f);
    chk(hte == '1 && hce == '0, req, {what, " host enables"}, {hte, hce}, 12'hfc0);
    chk(!rt && !rc && rte && rce, req, {what, " reference legs"}, {rt, rc, rte, rce}, 4'b0011);
  endtask

  // Collects 33 half-cycle samples and checks ratio and enables of all pairs
  task automatic measure(input int di, input int dout, input int dr, input string rq_h,
                         input string rq_o, input string rq_r);
    int rises [0:6];
    int bad_en [0:6];
    int bad_inv [0:6];
    logic prev [0:6];
    for (int o = 0; o < 7; o++) begin rises[o] = 0; bad_en[o] = 0; bad_inv[o] = 0; end
    for (int k = 0; k < 33; k++) begin
      if (k % 2 == 0) @(posedge clk); else @(negedge clk);
      #(P/4);
      for (int o = 0; o < 7; o++) begin
        logic t, c, te, ce;
        int d;
        if (o < NH) begin
          t = ht[o]; c = hc[o]; te = hte[o]; ce = hce[o];
          d = (o == 0 || o == NH-1) ? dout : di;
        end else begin
          t = rt; c = rc; te = rte; ce = rce; d = dr;
        end
        if (d == 0) begin
          if (te || ce || t || c) bad_en[o]++;
        end else begin
          if (!te || !ce) bad_en[o]++;
          if (c != ~t) bad_inv[o]++;
        end
        if (k > 0 && t && !prev[o]) rises[o]++;
        prev[o] = t;
      end
    end
    for (int o = 0; o < 7; o++) begin
      int d;
      string rq;
      if (o < NH) begin
        d  = (o == 0 || o == NH-1) ? dout : di;
        rq = (o == 0 || o == NH-1) ? rq_o : rq_h;
      end else begin
        d = dr; rq = rq_r;
      end
      chk(rises[o] == ((d == 0) ? 0 : 16 / d), rq, $sformatf("pair %0d rising edges", o),
          rises[o], (d == 0) ? 0 : 16 / d);
      chk(bad_en[o] == 0, rq, $sformatf("pair %0d enable/off samples bad", o), bad_en[o], 0);
      if (d != 0)
        chk(bad_inv[o] == 0, "R10", $sformatf("pair %0d complement samples bad", o), bad_inv[o], 0);
    end
  endtask

  // Raises power-down at a falling edge and checks the restart timing
  task automatic release_pd();
    @(negedge clk);
    pd_n = 1'b1;
    @(posedge clk); #(P/4);
    chk_safe("R6", "after first edge of release");
    @(posedge clk); #(P/4);
    chk(hte == '1 && ht == '0, "R6", "host /2 low in first running cycle", {hte, ht}, 12'hfc0);
    chk(rte && !rt, "R6", "ref /4 low in first running cycle", {rte, rt}, 2'b10);
    @(posedge clk); #(P/4);
    chk(ht == '1, "R6", "host /2 high in second running cycle", ht, 6'h3f);
  endtask

  initial begin : watchdog
    #(P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    summary();
  end

  initial begin : main
    // reset state: power-down held from time zero
    #(P/4);
    chk_safe("R5", "reset state");
    repeat (3) @(posedge clk);
    #(P/4);
    chk_safe("R5", "held power-down");

    // R9: settled pin defaults
    sel = 3'b000; tst = 1'b0; mcode = 2'b01;
    release_pd();
    chk(mult == 3'd6, "R9", "default multiplier", mult, 6);
    measure(2, 2, 4, "R9", "R9", "R9");

    // R8: multiplier decode
    begin
      int exp_m [0:3] = '{5, 6, 4, 7};
      for (int m = 0; m < 4; m++) begin
        @(negedge clk); mcode = m[1:0]; #1;
        chk(mult == exp_m[m][2:0], "R8", $sformatf("multiplier code %0d", m), mult, exp_m[m]);
      end
      mcode = 2'b01;
    end

    // table walk
    for (int v = 0; v < 10; v++) begin
      logic [13:0] e = VEC[v];
      @(negedge clk);
      tst = e[12]; sel = e[11:9]; pd_n = e[13];
      if (!e[13]) begin
        #1;
        chk_safe("R5", "asynchronous power-down with test-disable high");
        repeat (4) @(posedge clk);
        #(P/4);
        chk_safe("R5", "power-down held across edges");
        tst = 1'b0; sel = 3'b000;
        release_pd();
      end else begin
        repeat (10) @(posedge clk);
        if (e[12]) measure(0, 0, 0, "R4", "R4", "R4");
        else measure(e[8:6], e[5:3], e[2:0], "R1", "R2", "R3");
      end
    end

    // R7: select change waits for the counter wrap
    begin
      logic prev_r = 1'b0;
      int tries = 0;
      repeat (6) @(posedge clk);
      forever begin
        @(posedge clk); #(P/4);
        tries++;
        if ((prev_r && !rt) || tries > 20) break;
        prev_r = rt;
      end
      @(negedge clk); sel = 3'b100;
      @(posedge clk); #(P/4);
      @(posedge clk); #(P/4);
      chk(ht[1] == 1'b0, "R7", "inner pair still /2 before wrap", ht[1], 0);
      chk(ht[0] == 1'b0, "R7", "outer pair still /2 before wrap", ht[0], 0);
      repeat (4) @(posedge clk);
      #(P/4);
      chk(ht == '1, "R7", "all hosts /1 high after wrap", ht, 6'h3f);
      @(negedge clk); #(P/4);
      chk(ht == '0, "R7", "all hosts /1 low phase after wrap", ht, 0);
    end

    // R10: duty cycle and phase alignment at /2 and /4
    @(negedge clk); sel = 3'b000;
    repeat (10) @(posedge clk);
    begin
      int hi_h = 0, hi_r = 0, split = 0;
      for (int k = 0; k < 32; k++) begin
        if (k % 2 == 0) @(posedge clk); else @(negedge clk);
        #(P/4);
        if (ht[2]) hi_h++;
        if (rt) hi_r++;
        if (ht != '0 && ht != '1) split++;
      end
      chk(hi_h == 16, "R10", "host /2 high samples of 32", hi_h, 16);
      chk(hi_r == 16, "R10", "ref /4 high samples of 32", hi_r, 16);
      chk(split == 0, "R10", "samples with host pairs out of phase", split, 0);
    end

    summary();
  end

endmodule